// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a single-cycle 32-bit processor core. It finishes one instruction on every rising clock edge. It fetches from an internal word-indexed instruction store and computes the next program counter from one of four sources. Results go to a 32-entry register file whose entry zero always reads as zero. It supports word and byte loads, word and byte stores, set-less-than, load-upper, two conditional branches, an absolute jump, a jump through a register, and a fused memory-plus-register add. Loads and stores use a data store that is split into four byte lanes.

The core is meant to sit in a larger test or control environment. The instruction store is written by the surrounding environment before reset is released. The only inputs are the clock and an active-low synchronous reset. For observation, the core exposes the current program counter and a combinational read port into the register file. An unrecognised instruction leaves all architectural state unchanged except the program counter, which still moves to the next word.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter and every register are cleared to zero on that edge.
- R2: Register 0 reads as zero at all times, including after an instruction names it as destination.
- R3: These opcode/funct encodings write rd with the listed result: opcode 0 with funct 0x20 (add), 0x22 (sub), 0x24 (and), 0x25 (or), 0x27 (nor) and 0x26 (xor). These opcodes write rt with rs combined with the sign-extended 16-bit immediate: 0x08 (add), 0x0C (and), 0x0D (or) and 0x0E (xor). All arithmetic wraps modulo 2^32.
- R4: Opcode 0 with funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise. The result is correct even when rs minus rt overflows.
- R5: Opcode 0x0F writes rt with the 16-bit immediate in bits 31:16 and zeros in bits 15:0.
- R6: The next program counter is PC+4 unless a taken branch or a jump applies. Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets the PC to PC+4 plus the sign-extended immediate times four.
- R7: Opcode 0x02 sets the PC to PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R8: Opcode 0 with funct 0x08 sets the PC to the value of rs.
- R9: Opcode 0x2B stores rt at the word addressed by rs plus the sign-extended immediate. Opcode 0x23 loads that word into rt.
- R10: Opcode 0x24 loads one byte and zero-extends it into rt. Address low bits 0 select bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16 and 3 selects bits 31:24.
- R11: Opcode 0x28 writes bits 7:0 of rt into only the addressed byte lane, using the lane numbering of R10. The other three lanes of that word keep their contents.
- R12: Opcode 0 with funct 0x2C writes rd with the memory word at address R[rs] plus R[rt].
- R13: Any other opcode/funct combination writes no register and no memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_sel | input | 5 | Register index for the observation port |
| dbg_data | output | 32 | Combinational contents of the selected register |
| pc_out | output | 32 | Current program counter |

## Verification
Several properties are checked on every cycle:
- the PC is zero after a reset edge;
- a fallthrough advances the PC by four, and a taken branch or register jump lands on the target implied by the previous cycle's state;
- the set-less-than bit agrees with a signed comparison of the operands;
- an illegal instruction never raises a register or memory write strobe;
- a byte store enables exactly one lane.

Only the bench scenarios can show the data results. These include the arithmetic over the sweep of boundary operands, the preservation of untouched byte lanes and of register 0, the byte extraction order, the fused memory add, and the absolute jump targets.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
// sc_core_pkg: opcode and function codes, ALU operation and next-PC
// encodings, and the control bundle passed from the decoder to the datapath.
// Assumes the classic 32-bit three-register instruction layout.
package sc_core_pkg;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_JUMP    = 6'h02;
    localparam logic [5:0] OPC_BEQ     = 6'h04;
    localparam logic [5:0] OPC_BNE     = 6'h05;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_ANDI    = 6'h0C;
    localparam logic [5:0] OPC_ORI     = 6'h0D;
    localparam logic [5:0] OPC_XORI    = 6'h0E;
    localparam logic [5:0] OPC_UPPER   = 6'h0F;
    localparam logic [5:0] OPC_LDWORD  = 6'h23;
    localparam logic [5:0] OPC_LDBYTE  = 6'h24;
    localparam logic [5:0] OPC_STBYTE  = 6'h28;
    localparam logic [5:0] OPC_STWORD  = 6'h2B;

    localparam logic [5:0] FN_JREG   = 6'h08;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_SUB    = 6'h22;
    localparam logic [5:0] FN_AND    = 6'h24;
    localparam logic [5:0] FN_OR     = 6'h25;
    localparam logic [5:0] FN_XOR    = 6'h26;
    localparam logic [5:0] FN_NOR    = 6'h27;
    localparam logic [5:0] FN_LESS   = 6'h2A;
    localparam logic [5:0] FN_MEMADD = 6'h2C;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd2,
        ALU_SUB = 3'd3,
        ALU_AND = 3'd4,
        ALU_OR  = 3'd5,
        ALU_NOR = 3'd6,
        ALU_XOR = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2,
        NPC_REG    = 2'd3
    } npc_sel_e;

    typedef struct packed {
        alu_op_e  alu_op;
        logic     reg_we;
        logic     dst_is_rt;
        logic     use_imm;
        npc_sel_e npc_sel;
        logic     load_sel;
        logic     store_word;
        logic     store_byte;
        logic     load_byte;
        logic     is_upper;
        logic     is_less;
        logic     is_memadd;
        logic     illegal;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
// sc_decode: purely combinational control decoder.
// Maps opcode/funct plus the ALU zero flag to the control bundle.
// Assumes every write strobe defaults low, so illegal encodings are inert.
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       alu_zero,
    output ctrl_t      ctrl
);

    // Decode the instruction fields into control signals.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op  = ALU_ADD;
        ctrl.npc_sel = NPC_SEQ;
        case (opcode)
            OPC_SPECIAL: begin
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_ADD:    ctrl.alu_op = ALU_ADD;
                    FN_SUB:    ctrl.alu_op = ALU_SUB;
                    FN_AND:    ctrl.alu_op = ALU_AND;
                    FN_OR:     ctrl.alu_op = ALU_OR;
                    FN_XOR:    ctrl.alu_op = ALU_XOR;
                    FN_NOR:    ctrl.alu_op = ALU_NOR;
                    FN_LESS: begin
                        ctrl.alu_op  = ALU_SUB;
                        ctrl.is_less = 1'b1;
                    end
                    FN_MEMADD: ctrl.is_memadd = 1'b1;
                    FN_JREG: begin
                        ctrl.reg_we  = 1'b0;
                        ctrl.npc_sel = NPC_REG;
                    end
                    default: begin
                        ctrl.reg_we  = 1'b0;
                        ctrl.illegal = 1'b1;
                    end
                endcase
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI, OPC_XORI: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.use_imm   = 1'b1;
                case (opcode)
                    OPC_ANDI: ctrl.alu_op = ALU_AND;
                    OPC_ORI:  ctrl.alu_op = ALU_OR;
                    OPC_XORI: ctrl.alu_op = ALU_XOR;
                    default:  ctrl.alu_op = ALU_ADD;
                endcase
            end
            OPC_UPPER: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.is_upper  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_op  = ALU_SUB;
                ctrl.npc_sel = alu_zero ? NPC_BRANCH : NPC_SEQ;
            end
            OPC_BNE: begin
                ctrl.alu_op  = ALU_SUB;
                ctrl.npc_sel = alu_zero ? NPC_SEQ : NPC_BRANCH;
            end
            OPC_JUMP: ctrl.npc_sel = NPC_JUMP;
            OPC_LDWORD, OPC_LDBYTE: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.load_sel  = 1'b1;
                ctrl.load_byte = (opcode == OPC_LDBYTE);
            end
            OPC_STWORD: begin
                ctrl.use_imm    = 1'b1;
                ctrl.store_word = 1'b1;
            end
            OPC_STBYTE: begin
                ctrl.use_imm    = 1'b1;
                ctrl.store_byte = 1'b1;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
// sc_alu: combinational integer ALU with zero, negative and signed-overflow flags.
// Assumes two's-complement operands; the overflow flag is meaningful for add and sub only.
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero,
    output logic         neg,
    output logic         ovf
);

    // Select the operation result.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_XOR: y = a ^ b;
            default: y = a + b;
        endcase
    end

    // Derive the status flags from the operands and the result.
    always_comb begin
        zero = (y == '0);
        neg  = y[W-1];
        case (op)
            ALU_ADD: ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
            ALU_SUB: ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
            default: ovf = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
// sc_regfile: 32-entry register file with three combinational read ports and one write port.
// Entry 0 is never written and reads as zero. Every entry clears on a synchronous active-low reset.
module sc_regfile #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   ra_a,
    input  logic [4:0]   ra_b,
    input  logic [4:0]   ra_c,
    output logic [W-1:0] rd_a,
    output logic [W-1:0] rd_b,
    output logic [W-1:0] rd_c,
    input  logic         we,
    input  logic [4:0]   wa,
    input  logic [W-1:0] wd
);

    localparam int DEPTH = 32;

    logic [W-1:0] regs_q [DEPTH];

    // Clear on reset, otherwise write any entry except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
        end else if (we && (wa != 5'd0)) begin
            regs_q[wa] <= wd;
        end
    end

    // Read ports, with entry zero forced to zero.
    always_comb begin
        rd_a = (ra_a == 5'd0) ? '0 : regs_q[ra_a];
        rd_b = (ra_b == 5'd0) ? '0 : regs_q[ra_b];
        rd_c = (ra_c == 5'd0) ? '0 : regs_q[ra_c];
    end

endmodule

// File: rtl/sc_rom.sv
`timescale 1ns/1ps
// sc_rom: word-indexed instruction store with a combinational read.
// Contents start at zero and are written by the surrounding environment before use.
module sc_rom #(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic [AW-1:0] idx,
    output logic [31:0]   data
);

    logic [31:0] mem [WORDS];

    // Start every word at zero.
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    // Combinational fetch.
    assign data = mem[idx];

endmodule

// File: rtl/sc_dmem.sv
`timescale 1ns/1ps
// sc_dmem: data store built from one array per byte lane.
// A word write enables every lane. A byte write enables only the lane chosen by
// the low address bits and drives bits 7:0 of the write data onto it.
// Reads are combinational; the store has no reset.
module sc_dmem #(
    parameter int W     = 32,
    parameter int WORDS = 64,
    localparam int LANES = W / 8,
    localparam int LSB   = $clog2(LANES),
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW+LSB-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              word_we,
    input  logic              byte_we,
    output logic [W-1:0]      rdata
);

    logic [AW-1:0]    idx;
    logic [LANES-1:0] lane_we;

    assign idx = addr[AW+LSB-1:LSB];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_q [WORDS];
        logic [7:0] lane_wd;

        assign lane_we[l] = word_we | (byte_we & (addr[LSB-1:0] == LSB'(l)));
        assign lane_wd    = word_we ? wdata[8*l +: 8] : wdata[7:0];

        // Store this lane's byte when it is enabled.
        always_ff @(posedge clk) begin
            if (lane_we[l]) lane_q[idx] <= lane_wd;
        end

        assign rdata[8*l +: 8] = lane_q[idx];
    end

    // R11: a byte store touches exactly one lane.
    assert_single_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |-> ($countones(lane_we) == 1));

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
// sc_core: single-cycle 32-bit core. It ties together the program counter,
// the decoder, the register file, the ALU, the byte-lane data store and the
// write-back and next-PC selection.
// Assumes the instruction store is filled before rst_n is released, and that
// the store sizes are powers of two (addresses wrap inside them).
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 64,
    localparam int W   = 32,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   dbg_sel,
    output logic [W-1:0] dbg_data,
    output logic [W-1:0] pc_out
);

    logic [W-1:0] pc_q, pc_next, pc_plus4;
    logic [W-1:0] inst;
    ctrl_t        ctrl;
    logic [W-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y;
    logic         alu_zero, alu_neg, alu_ovf, lt_bit;
    logic [4:0]   dst;
    logic [W-1:0] dmem_rdata, load_val, memadd_sum, wb_data;
    logic [7:0]   load_byte_v;

    // Program counter register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_out = pc_q;

    sc_rom #(.WORDS(IMEM_WORDS)) u_rom (
        .idx  (pc_q[IAW+1:2]),
        .data (inst)
    );

    sc_decode u_dec (
        .opcode   (inst[31:26]),
        .funct    (inst[5:0]),
        .alu_zero (alu_zero),
        .ctrl     (ctrl)
    );

    assign dst = ctrl.dst_is_rt ? inst[20:16] : inst[15:11];

    sc_regfile #(.W(W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (inst[25:21]),
        .ra_b  (inst[20:16]),
        .ra_c  (dbg_sel),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .rd_c  (dbg_data),
        .we    (ctrl.reg_we),
        .wa    (dst),
        .wd    (wb_data)
    );

    assign imm_ext = {{(W-16){inst[15]}}, inst[15:0]};

    // Second ALU operand: zero for the fused add's address, else immediate or rt.
    always_comb begin
        if (ctrl.is_memadd)    alu_b = '0;
        else if (ctrl.use_imm) alu_b = imm_ext;
        else                   alu_b = rt_val;
    end

    sc_alu #(.W(W)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero),
        .neg  (alu_neg),
        .ovf  (alu_ovf)
    );

    sc_dmem #(.W(W), .WORDS(DMEM_WORDS)) u_dmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (alu_y[DAW+1:0]),
        .wdata   (rt_val),
        .word_we (ctrl.store_word),
        .byte_we (ctrl.store_byte),
        .rdata   (dmem_rdata)
    );

    // Signed less-than that stays correct when the subtraction overflows.
    assign lt_bit = alu_neg ^ alu_ovf;

    // Byte extraction for loads and the second adder for the fused add.
    always_comb begin
        load_byte_v = dmem_rdata[{alu_y[1:0], 3'b000} +: 8];
        load_val    = ctrl.load_byte ? {{(W-8){1'b0}}, load_byte_v} : dmem_rdata;
        memadd_sum  = dmem_rdata + rt_val;
    end

    // Write-back source selection.
    always_comb begin
        if (ctrl.is_upper)       wb_data = {inst[15:0], 16'h0000};
        else if (ctrl.is_less)   wb_data = {{(W-1){1'b0}}, lt_bit};
        else if (ctrl.load_sel)  wb_data = load_val;
        else if (ctrl.is_memadd) wb_data = memadd_sum;
        else                     wb_data = alu_y;
    end

    // Four-way next-PC selection.
    always_comb begin
        pc_plus4 = pc_q + 32'd4;
        case (ctrl.npc_sel)
            NPC_BRANCH: pc_next = pc_plus4 + {imm_ext[W-3:0], 2'b00};
            NPC_JUMP:   pc_next = {pc_q[W-1:W-4], inst[25:0], 2'b00};
            NPC_REG:    pc_next = rs_val;
            default:    pc_next = pc_plus4;
        endcase
    end

    // R1: a reset edge leaves the PC at zero.
    assert_pc_cleared_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0));

    // R6: fallthrough advances by one word.
    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.npc_sel == NPC_SEQ) |=> (pc_q == $past(pc_q) + 32'd4));

    // R6: a taken branch lands at PC+4 plus the scaled offset.
    assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.npc_sel == NPC_BRANCH) |=>
            (pc_q == $past(pc_q) + 32'd4 + {$past(imm_ext[W-3:0]), 2'b00}));

    // R8: a register jump lands at the old rs value.
    assert_jreg_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.npc_sel == NPC_REG) |=> (pc_q == $past(rs_val)));

    // R4: the less-than bit matches a signed comparison.
    assert_less_signed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_less |-> (lt_bit == ($signed(rs_val) < $signed(rt_val))));

    // R13: an illegal encoding raises no write strobe.
    assert_illegal_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.illegal |-> !(ctrl.reg_we || ctrl.store_word || ctrl.store_byte));

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dbg_sel = 5'd0;
    logic [31:0] dbg_data, pc_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int wp    = 0;

    always #2.5 clk = ~clk;

    sc_core dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data),
        .pc_out   (pc_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] t);
        return {6'h02, t};
    endfunction

    function automatic logic [31:0] val(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'h1234_5678;
            6: return 32'hFFFE_0001;
            default: return 32'h0000_FFFF;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rdreg(int r, output logic [31:0] v);
        dbg_sel = 5'(r);
        #0.5;
        v = dbg_data;
    endtask

    task automatic emit(logic [31:0] w);
        dut.u_rom.mem[wp] = w;
        wp++;
    endtask

    task automatic start_prog();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) dut.u_rom.mem[i] = 32'h0;
        wp = 0;
    endtask

    task automatic load_val(int rd, logic [31:0] v);
        logic [15:0] hi;
        hi = v[31:16] + {15'd0, v[15]};
        emit(enc_i(6'h0F, 0, rd, hi));
        emit(enc_i(6'h08, rd, rd, v[15:0]));
    endtask

    task automatic halt();
        emit(enc_j(26'(wp)));
    endtask

    task automatic go(int n);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] a, b, v, exp;
        logic [15:0] imm;
        logic [31:0] immx;
        repeat (2) @(negedge clk);

        // R3 R4 R5 R2: sweep over pairs of boundary operands
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = val(i);
                b = val(j);
                imm = 16'((i * 8 + j) * 1021) ^ ((j % 2 == 1) ? 16'h8000 : 16'h0000);
                immx = {{16{imm[15]}}, imm};
                start_prog();
                load_val(1, a);
                load_val(2, b);
                emit(enc_r(1, 2, 3, 6'h20));
                emit(enc_r(1, 2, 4, 6'h22));
                emit(enc_r(1, 2, 5, 6'h24));
                emit(enc_r(1, 2, 6, 6'h25));
                emit(enc_r(1, 2, 7, 6'h27));
                emit(enc_r(1, 2, 8, 6'h26));
                emit(enc_r(1, 2, 9, 6'h2A));
                emit(enc_r(2, 1, 15, 6'h2A));
                emit(enc_i(6'h08, 1, 10, imm));
                emit(enc_i(6'h0C, 1, 11, imm));
                emit(enc_i(6'h0D, 1, 12, imm));
                emit(enc_i(6'h0E, 1, 13, imm));
                emit(enc_i(6'h0F, 0, 14, imm));
                emit(enc_r(1, 2, 0, 6'h20));
                halt();
                go(22);
                rdreg(1, v);  chk("R3 load rs", v, a);
                rdreg(2, v);  chk("R3 load rt", v, b);
                rdreg(3, v);  chk("R3 add", v, a + b);
                rdreg(4, v);  chk("R3 sub", v, a - b);
                rdreg(5, v);  chk("R3 and", v, a & b);
                rdreg(6, v);  chk("R3 or", v, a | b);
                rdreg(7, v);  chk("R3 nor", v, ~(a | b));
                rdreg(8, v);  chk("R3 xor", v, a ^ b);
                exp = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                rdreg(9, v);  chk("R4 slt a<b", v, exp);
                exp = ($signed(b) < $signed(a)) ? 32'd1 : 32'd0;
                rdreg(15, v); chk("R4 slt b<a", v, exp);
                rdreg(10, v); chk("R3 addi", v, a + immx);
                rdreg(11, v); chk("R3 andi", v, a & immx);
                rdreg(12, v); chk("R3 ori", v, a | immx);
                rdreg(13, v); chk("R3 xori", v, a ^ immx);
                rdreg(14, v); chk("R5 lui", v, {imm, 16'h0000});
                rdreg(0, v);  chk("R2 reg zero", v, 32'h0);
                chk("R6 fallthrough pc", pc_out, 32'd72);
            end
        end

        // R1: reset clears the PC and every register
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 pc reset", pc_out, 32'h0);
        for (int r = 0; r < 32; r++) begin
            rdreg(r, v);
            chk("R1 reg reset", v, 32'h0);
        end

        // R13: illegal encodings leave state alone
        start_prog();
        load_val(1, 32'h1234_5678);
        load_val(2, 32'hAAAA_5555);
        emit(enc_i(6'h2B, 0, 1, 16'd16));
        emit(enc_i(6'h29, 0, 2, 16'd16));
        emit(enc_i(6'h3F, 0, 1, 16'h1111));
        emit(enc_r(2, 2, 1, 6'h01));
        emit(enc_r(2, 2, 1, 6'h21));
        emit(enc_i(6'h23, 0, 3, 16'd16));
        halt();
        go(14);
        rdreg(1, v); chk("R13 reg untouched", v, 32'h1234_5678);
        rdreg(3, v); chk("R13 mem untouched", v, 32'h1234_5678);
        chk("R13 pc advances", pc_out, 32'd40);

        // R9 R10 R11 R12: word and byte traffic for each lane
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] w, bb, merged;
                w  = 32'hA1B2_C3D4 + 32'(p) * 32'h0707_0707;
                bb = 32'h0000_00E7 ^ (32'(p) * 32'h1357_9BDF);
                merged = w;
                merged[8*k +: 8] = bb[7:0];
                start_prog();
                load_val(1, w);
                load_val(2, bb);
                emit(enc_i(6'h2B, 0, 1, 16'd32));
                emit(enc_i(6'h2B, 0, 1, 16'd36));
                emit(enc_i(6'h28, 0, 2, 16'(36 + k)));
                emit(enc_i(6'h23, 0, 3, 16'd36));
                emit(enc_i(6'h23, 0, 4, 16'd32));
                emit(enc_i(6'h24, 0, 5, 16'(32 + k)));
                emit(enc_i(6'h08, 0, 6, 16'd32));
                emit(enc_r(6, 2, 7, 6'h2C));
                emit(enc_i(6'h24, 6, 9, 16'(4 + k)));
                emit(enc_i(6'h24, 6, 10, 16'(4 + (k + 1) % 4)));
                halt();
                go(18);
                rdreg(3, v);  chk("R11 byte store merge", v, merged);
                rdreg(4, v);  chk("R9 word store/load", v, w);
                rdreg(5, v);  chk("R10 byte load lane", v, {24'h0, w[8*k +: 8]});
                rdreg(7, v);  chk("R12 memory add", v, w + bb);
                rdreg(9, v);  chk("R11 stored byte", v, {24'h0, bb[7:0]});
                rdreg(10, v); chk("R11 other lane kept", v, {24'h0, w[8*((k + 1) % 4) +: 8]});
                chk("R6 fallthrough pc", pc_out, 32'd56);
            end
        end

        // R6: both branch types, taken and not taken, several offsets
        for (int op = 4; op <= 5; op++) begin
            for (int eq = 0; eq < 2; eq++) begin
                for (int oi = 0; oi < 5; oi++) begin
                    int off;
                    logic taken;
                    case (oi)
                        0: off = -5;
                        1: off = -1;
                        2: off = 0;
                        3: off = 1;
                        default: off = 7;
                    endcase
                    taken = (op == 4) ? (eq == 1) : (eq == 0);
                    start_prog();
                    load_val(1, 32'h8000_0001);
                    load_val(2, (eq == 1) ? 32'h8000_0001 : 32'h8001_0001);
                    emit(enc_i(6'(op), 1, 2, 16'(off)));
                    go(5);
                    exp = taken ? 32'(20 + 4 * off) : 32'd20;
                    chk("R6 branch pc", pc_out, exp);
                end
            end
        end

        // R7: absolute jump targets
        for (int t = 0; t < 4; t++) begin
            logic [25:0] tg;
            case (t)
                0: tg = 26'd1;
                1: tg = 26'h10;
                2: tg = 26'h3FF_FFFF;
                default: tg = 26'h2AA_AAAA;
            endcase
            start_prog();
            emit(enc_j(tg));
            go(1);
            chk("R7 jump target", pc_out, {4'h0, tg, 2'b00});
        end

        // R8 then R7: register jump to a high address, then a jump keeps PC[31:28]
        start_prog();
        load_val(1, 32'h3000_0040);
        emit(enc_r(1, 0, 0, 6'h08));
        dut.u_rom.mem[16] = enc_j(26'd5);
        go(3);
        chk("R8 register jump", pc_out, 32'h3000_0040);
        @(negedge clk);
        chk("R7 jump keeps top bits", pc_out, 32'h3000_0014);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule